// File: doc/BRIEF.md
# Interrupt rate moderation controller

This block limits how often one event-ring interrupter can raise an interrupt. It does this by forcing a minimum gap between successive interrupts. Software programs a 16-bit interval in units of a 250 ns time base. A 16-bit down counter is loaded from that interval each time software acknowledges an interrupt by clearing the pending flag. The counter then steps down on every time-base tick until it reaches zero. A new interrupt can only be raised once the counter has reached zero.

Software reaches the block through a small 32-bit register port with two word addresses. One word holds the live counter and the interval. The other word holds an enable bit and a pending bit that is cleared by writing 1. The inputs that gate the interrupt are a ring-not-empty status, an event-handler-busy flag and a one-cycle tick strobe that occurs every 250 ns. The output is a registered level interrupt request. An interval of zero turns the throttle off, so an interrupt follows the next event at once.

Top module: `irq_throttle`

## Requirements
- R1: After synchronous reset the interval reads 0x0FA0 (4000), the counter reads 0, enable and pending read 0, and `irq` is 0.
- R2: Register address 0 reads and writes the counter in bits 31:16 and the interval in bits 15:0. Address 1 holds enable in bit 1 (read/write) and pending in bit 0. All other bits of address 1 read 0. Read data appears on `reg_rdata` one cycle after `reg_addr` is presented.
- R3: A `tick` strobe decrements a nonzero counter by one.
- R4: A `tick` while the counter is 0 leaves it at 0, so it never wraps.
- R5: Writing address 1 with bit 0 set clears pending and loads the counter from the interval. Writing bit 0 as 0 leaves pending unchanged.
- R6: Hardware sets pending when the throttle is open, `ring_nonempty` is 1 and `handler_busy` is 0. The throttle is open when the counter is 0 or the interval is 0. `handler_busy` = 1 holds pending off.
- R7: `irq` is 1 exactly one cycle after a cycle in which enable, pending, the open throttle, `ring_nonempty` and not `handler_busy` all held.
- R8: With an interval of 0, interrupts are not throttled even if the counter holds a nonzero value.
- R9: A software write to the counter field takes effect in the next cycle, and ticks continue counting down from the written value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 1 | Word address for reads and writes (0 = counter/interval, 1 = control) |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Registered read data |
| tick | input | 1 | One-cycle 250 ns time-base strobe |
| ring_nonempty | input | 1 | Event ring holds unserviced events |
| handler_busy | input | 1 | Event handler is busy; blocks new interrupts |
| irq | output | 1 | Registered level interrupt request |

## Verification
The checker module verifies on every cycle the reset values, the one-step countdown, the hold at zero, the reload on clear, the write-1-to-clear rule for pending, the effect of register writes, and the gating condition behind each assertion of `irq`. Some behaviour depends on a whole scenario and only the bench can show it. This covers the length of the enforced gap in ticks, the bypass when the interval is zero and a nonzero counter has been written, and the full truth table of enable, ring status and busy. The bench drives these through the register port and checks them.

// File: rtl/irqm_pkg.sv
package irqm_pkg;
  localparam logic ADDR_MOD  = 1'b0;
  localparam logic ADDR_CTRL = 1'b1;
  localparam int   CTRL_PEND_BIT = 0;
  localparam int   CTRL_EN_BIT   = 1;

  typedef struct packed {
    logic mod_wr;
    logic en_wr;
    logic pend_clr;
  } wr_cmd_t;
endpackage

// File: rtl/irqm_decode.sv
module irqm_decode
  import irqm_pkg::*;
(
  input  logic    reg_wr,
  input  logic    reg_addr,
  input  logic    clr_bit,
  output wr_cmd_t cmd
);
  always_comb begin
    cmd.mod_wr   = reg_wr && (reg_addr == ADDR_MOD);
    cmd.en_wr    = reg_wr && (reg_addr == ADDR_CTRL);
    cmd.pend_clr = reg_wr && (reg_addr == ADDR_CTRL) && clr_bit;
  end
endmodule

// File: rtl/irqm_counter.sv
module irqm_counter #(
  parameter int CNT_W = 16,
  parameter logic [CNT_W-1:0] INTV_RST = CNT_W'(4000)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             mod_wr,
  input  logic [CNT_W-1:0] wr_cnt,
  input  logic [CNT_W-1:0] wr_intv,
  input  logic             reload,
  output logic [CNT_W-1:0] cnt,
  output logic [CNT_W-1:0] intv,
  output logic             cnt_zero,
  output logic             intv_zero
);
  always_ff @(posedge clk) begin
    if (rst) begin
      cnt  <= '0;
      intv <= INTV_RST;
    end else begin
      if (mod_wr) begin
        // software write wins over any reload or tick in the same cycle
        cnt  <= wr_cnt;
        intv <= wr_intv;
      end else if (reload) begin
        cnt <= intv;
      end else if (tick && cnt != '0) begin
        cnt <= cnt - 1'b1;
      end
    end
  end

  assign cnt_zero  = (cnt == '0);
  assign intv_zero = (intv == '0);
endmodule

// File: rtl/irqm_flags.sv
module irqm_flags (
  input  logic clk,
  input  logic rst,
  input  logic set_req,
  input  logic pend_clr,
  input  logic en_wr,
  input  logic en_val,
  output logic en,
  output logic pend
);
  always_ff @(posedge clk) begin
    if (rst) begin
      en   <= 1'b0;
      pend <= 1'b0;
    end else begin
      if (en_wr) en <= en_val;
      if (pend_clr)     pend <= 1'b0;
      else if (set_req) pend <= 1'b1;
    end
  end
endmodule

// File: rtl/irq_throttle.sv
module irq_throttle
  import irqm_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter logic [CNT_W-1:0] INTV_RST = CNT_W'(4000),
  localparam int DATA_W = 2 * CNT_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr,
  input  logic              reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              tick,
  input  logic              ring_nonempty,
  input  logic              handler_busy,
  output logic              irq
);
  wr_cmd_t          cmd;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] intv;
  logic             cnt_zero;
  logic             intv_zero;
  logic             en;
  logic             pend;
  logic             gate_open;
  logic             event_ready;

  irqm_decode u_dec (
    .reg_wr   (reg_wr),
    .reg_addr (reg_addr),
    .clr_bit  (reg_wdata[CTRL_PEND_BIT]),
    .cmd      (cmd)
  );

  irqm_counter #(.CNT_W(CNT_W), .INTV_RST(INTV_RST)) u_cnt (
    .clk       (clk),
    .rst       (rst),
    .tick      (tick),
    .mod_wr    (cmd.mod_wr),
    .wr_cnt    (reg_wdata[DATA_W-1:CNT_W]),
    .wr_intv   (reg_wdata[CNT_W-1:0]),
    .reload    (cmd.pend_clr),
    .cnt       (cnt),
    .intv      (intv),
    .cnt_zero  (cnt_zero),
    .intv_zero (intv_zero)
  );

  assign gate_open   = cnt_zero | intv_zero;
  assign event_ready = gate_open & ring_nonempty & ~handler_busy;

  irqm_flags u_flags (
    .clk      (clk),
    .rst      (rst),
    .set_req  (event_ready),
    .pend_clr (cmd.pend_clr),
    .en_wr    (cmd.en_wr),
    .en_val   (reg_wdata[CTRL_EN_BIT]),
    .en       (en),
    .pend     (pend)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      irq       <= 1'b0;
      reg_rdata <= '0;
    end else begin
      irq <= en & pend & event_ready;
      if (reg_addr == ADDR_MOD) reg_rdata <= {cnt, intv};
      else                      reg_rdata <= {{(DATA_W-2){1'b0}}, en, pend};
    end
  end
endmodule

// File: rtl/irqm_checker.sv
module irqm_checker #(
  parameter int CNT_W = 16,
  parameter logic [CNT_W-1:0] INTV_RST = CNT_W'(4000)
) (
  input logic               clk,
  input logic               rst,
  input logic               reg_wr,
  input logic               reg_addr,
  input logic [2*CNT_W-1:0] reg_wdata,
  input logic               tick,
  input logic               ring_nonempty,
  input logic               handler_busy,
  input logic               irq,
  input logic [CNT_W-1:0]   cnt,
  input logic [CNT_W-1:0]   intv,
  input logic               en,
  input logic               pend
);
  logic mod_w, ctl_w, clr_w;
  assign mod_w = reg_wr && (reg_addr == 1'b0);
  assign ctl_w = reg_wr && (reg_addr == 1'b1);
  assign clr_w = ctl_w && reg_wdata[0];

  // R1
  reset_value_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (cnt == '0 && intv == INTV_RST && !en && !pend && !irq));

  // R2
  mod_write_chk: assert property (@(posedge clk) disable iff (rst)
    mod_w |=> (cnt == $past(reg_wdata[2*CNT_W-1:CNT_W]) && intv == $past(reg_wdata[CNT_W-1:0])));

  // R2
  en_write_chk: assert property (@(posedge clk) disable iff (rst)
    ctl_w |=> (en == $past(reg_wdata[1])));

  // R3
  countdown_chk: assert property (@(posedge clk) disable iff (rst)
    (tick && cnt != '0 && !mod_w && !clr_w) |=> ((cnt + 1'b1) == $past(cnt)));

  // R4
  no_underflow_chk: assert property (@(posedge clk) disable iff (rst)
    (cnt == '0 && !mod_w && !clr_w) |=> (cnt == '0));

  // R5
  reload_chk: assert property (@(posedge clk) disable iff (rst)
    (clr_w && !mod_w) |=> (cnt == $past(intv) && !pend));

  // R5
  pend_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (pend && !clr_w) |=> pend);

  // R6
  busy_blocks_chk: assert property (@(posedge clk) disable iff (rst)
    (!pend && (handler_busy || !ring_nonempty)) |=> !pend);

  // R7
  irq_gate_chk: assert property (@(posedge clk) disable iff (rst)
    irq |-> $past(en && pend && ring_nonempty && !handler_busy && (cnt == '0 || intv == '0)));
endmodule

bind irq_throttle irqm_checker #(.CNT_W(CNT_W), .INTV_RST(INTV_RST)) u_chk (
  .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
  .tick(tick), .ring_nonempty(ring_nonempty), .handler_busy(handler_busy), .irq(irq),
  .cnt(cnt), .intv(intv), .en(en), .pend(pend)
);

// File: tb/irq_throttle_test.sv
`timescale 1ns/1ps
module irq_throttle_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_wr = 1'b0;
  logic        reg_addr = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        tick = 1'b0;
  logic        ring_nonempty = 1'b0;
  logic        handler_busy = 1'b0;
  logic        irq;

  int checks = 0;
  int failures = 0;
  int cycles = 0;

  always #2.5 clk = ~clk;

  irq_throttle uut (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .tick(tick),
    .ring_nonempty(ring_nonempty), .handler_busy(handler_busy), .irq(irq)
  );

  // en, ring, busy, expected irq (interval 0)
  localparam logic [3:0] VEC [8] = '{4'b0000, 4'b0010, 4'b0100, 4'b0110,
                                     4'b1000, 4'b1010, 4'b1101, 4'b1110};

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      failures++;
      $display("FAIL watchdog: run hung, actual=%0d expected<=20000 cycles", cycles);
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wr(input logic a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0; reg_wdata = '0;
  endtask

  task automatic rd(input logic a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    @(negedge clk);
    d = reg_rdata;
  endtask

  task automatic pulse_tick();
    @(negedge clk);
    tick = 1'b1;
    @(negedge clk);
    tick = 1'b0;
  endtask

  initial begin
    logic [31:0] d;
    idle(3);
    rst = 1'b0;
    // R1 reset values
    rd(1'b0, d); check("R1 mod reg", d, 32'h0000_0FA0);
    rd(1'b1, d); check("R1 ctrl reg", d, 32'h0);
    check("R1 irq", {31'b0, irq}, 32'h0);

    // R7 gating table with interval 0
    wr(1'b0, 32'h0);
    for (int i = 0; i < 8; i++) begin
      ring_nonempty = VEC[i][2];
      handler_busy  = VEC[i][1];
      wr(1'b1, {30'b0, VEC[i][3], 1'b1});
      idle(4);
      check($sformatf("R7 vec%0d irq", i), {31'b0, irq}, {31'b0, VEC[i][0]});
    end

    // R2 register readback
    ring_nonempty = 1'b0; handler_busy = 1'b0;
    wr(1'b1, 32'h1);
    rd(1'b1, d); check("R2 ctrl en=0 pend=0", d, 32'h0);
    wr(1'b1, 32'h2);
    rd(1'b1, d); check("R2 ctrl en=1", d, 32'h2);
    wr(1'b0, 32'h1234_0056);
    rd(1'b0, d); check("R2 mod readback", d, 32'h1234_0056);

    // R3 / R9 live counter write then countdown
    wr(1'b0, {16'd5, 16'd100});
    rd(1'b0, d); check("R9 written counter", d, {16'd5, 16'd100});
    pulse_tick();
    rd(1'b0, d); check("R3 R9 tick from written value", d, {16'd4, 16'd100});

    // R4 hold at zero
    wr(1'b0, {16'd1, 16'd100});
    pulse_tick();
    rd(1'b0, d); check("R4 reached zero", d, {16'd0, 16'd100});
    pulse_tick(); pulse_tick();
    rd(1'b0, d); check("R4 no underflow", d, {16'd0, 16'd100});

    // R5 reload on clear, write-0 ignored
    wr(1'b0, {16'd0, 16'd9});
    wr(1'b1, 32'h3);
    rd(1'b0, d); check("R5 reload from interval", d, {16'd9, 16'd9});
    wr(1'b0, {16'd0, 16'd9});
    ring_nonempty = 1'b1;
    idle(3);
    rd(1'b1, d); check("R6 pend set", d, 32'h3);
    wr(1'b1, 32'h2);
    rd(1'b1, d); check("R5 write 0 keeps pend", d, 32'h3);
    rd(1'b0, d); check("R5 write 0 no reload", d, {16'd0, 16'd9});

    // R6 busy holds pending off
    handler_busy = 1'b1;
    wr(1'b1, 32'h3);
    wr(1'b0, {16'd0, 16'd9});
    idle(3);
    rd(1'b1, d); check("R6 busy blocks pend", d, 32'h2);
    handler_busy = 1'b0;
    idle(3);
    rd(1'b1, d); check("R6 pend after busy drops", d, 32'h3);

    // R7 moderation gap of 3 ticks
    wr(1'b0, {16'd0, 16'd3});
    wr(1'b1, 32'h3);
    idle(10);
    check("R7 throttled no tick", {31'b0, irq}, 32'h0);
    pulse_tick(); pulse_tick();
    idle(3);
    check("R7 throttled after 2 ticks", {31'b0, irq}, 32'h0);
    pulse_tick();
    idle(3);
    check("R7 irq after gap", {31'b0, irq}, 32'h1);

    // R8 interval 0 bypasses a nonzero counter
    ring_nonempty = 1'b0;
    wr(1'b1, 32'h3);
    wr(1'b0, {16'd7, 16'd0});
    ring_nonempty = 1'b1;
    idle(4);
    check("R8 irq despite counter", {31'b0, irq}, 32'h1);
    rd(1'b0, d); check("R8 counter untouched", d, {16'd7, 16'd0});

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule